// File: doc/BRIEF.md
# Masked Packed Double-to-Int64 Converter

This block turns up to eight IEEE-754 double-precision lanes into signed 64-bit integers in one registered stage. The vector length input sets how many 64-bit lanes take part. Lane `j` sits at bits `[64*j+63 : 64*j]` of both the source and the result. Result bits above the chosen length are cleared.

Each lane inside the length is written when masking is off or its mask bit is set. A lane that is not written either keeps the matching slice of the prior destination (merge) or is cleared (zero). A memory-form source with broadcast set feeds its lowest element to every lane.

Rounding normally follows the global mode. A register-form source at full length with the broadcast bit set takes the embedded mode instead. Values that cannot be held as a signed 64-bit integer give the fixed value 0x8000_0000_0000_0000 and raise the invalid flag. Inexact results raise the inexact flag. Both flags collect only over lanes that were written.

Top module: `vec_f2i_cvt`

## Requirements
- R1: `vlen_sel` 2'b00 selects 2 lanes, 2'b01 selects 4 lanes, and 2'b10 or 2'b11 selects 8 lanes. Lane j uses bits [64j+63:64j].
- R2: Every result bit at or above 64 × (selected lane count) is zero, whatever the mask, prior value or source.
- R3: A lane within the length whose write enable is true gets the converted integer of its source element. The write enable is `mask_en`=0 or `mask_bits[j]`=1.
- R4: A lane within the length whose write enable is false returns `prior_dst` lane j when `zero_mode`=0, and zero when `zero_mode`=1.
- R5: When `src_is_mem`=1 and `bcast`=1, every written lane converts `src_vec[63:0]`. A register-form source with `bcast`=1 converts its own lanes.
- R6: The rounding mode is `emb_rm` when `src_is_mem`=0, `bcast`=1 and 8 lanes are selected. Otherwise it is `gbl_rm`.
- R7: Mode encoding: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. A lane whose exact value is not an integer is rounded this way and raises inexact.
- R8: NaN (quiet or signalling), ±infinity, and finite values whose rounded result lies outside [−2^63, 2^63−1] yield 0x8000_0000_0000_0000 and raise invalid. Such a lane does not raise inexact.
- R9: −2^63 converts to 0x8000_0000_0000_0000 exactly, with neither flag raised.
- R10: `flag_invalid` and `flag_inexact` are the OR of per-lane flags over written lanes within the length only. Masked-off lanes add nothing, and neither do lanes beyond the length.
- R11: Zeros of both signs give 0 with no flag. A nonzero subnormal raises inexact and rounds by the mode: 0, except +1 for a positive value toward plus infinity and −1 for a negative value toward minus infinity.
- R12: The outputs are registered. They reflect the inputs sampled at the previous rising clock edge. While reset is active, and for two edges after it is released, the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| src_vec | input | 512 | Packed double-precision source lanes |
| vlen_sel | input | 2 | Vector length: 00 = 128, 01 = 256, 1x = 512 bits |
| mask_bits | input | 8 | Per-lane write mask |
| mask_en | input | 1 | 1 = apply `mask_bits`, 0 = write every lane |
| zero_mode | input | 1 | Inactive lanes: 1 = zero, 0 = keep prior |
| prior_dst | input | 512 | Prior destination value used for merging |
| bcast | input | 1 | Broadcast (memory form) or rounding-override select (register form) |
| src_is_mem | input | 1 | 1 = memory-form source, 0 = register-form source |
| gbl_rm | input | 2 | Global rounding mode |
| emb_rm | input | 2 | Embedded rounding mode override |
| res_vec | output | 512 | Packed signed 64-bit results |
| flag_invalid | output | 1 | Some written lane was not representable |
| flag_inexact | output | 1 | Some written lane was rounded |

## Verification
The assertions watch four things on every cycle:
- the cleared upper bits at the shortest length;
- a masked lane keeping its prior value under merge, or reading zero under zeroing;
- silent flags when every lane is masked off;
- equal lanes under a memory broadcast.

Only the bench's scenarios can show that the numbers themselves are right. That covers:
- ties-to-even and the directed modes on halves;
- the −2^63 and 2^63 edges;
- subnormals under each mode;
- NaN and infinity handling;
- whether the embedded mode or the global mode was chosen for a given form and length.

The bench checks each of these against a fixed-point reference that is independent of the RTL.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int unsigned LANE_W    = 64;
  localparam int unsigned MAX_LANES = 8;
  localparam int unsigned VEC_W     = LANE_W * MAX_LANES;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_MAN_W  = 52;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_DOWN      = 2'b01,
    RM_UP        = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512B = 2'b11
  } vlen_e;

  localparam logic [LANE_W-1:0] INDEF_Q = {1'b1, {(LANE_W-1){1'b0}}};
endpackage

// File: rtl/f2i_rm_pick.sv
module f2i_rm_pick
  import f2i_pkg::*;
(
  input  logic [1:0] gbl_rm,
  input  logic [1:0] emb_rm,
  input  logic       src_is_mem,
  input  logic       bcast,
  input  vlen_e      vlen,
  output rmode_e     rm_sel
);
  logic use_emb;

  // Override only for register form at full width with the override bit set
  always_comb begin
    use_emb = ~src_is_mem & bcast & ((vlen == VL_512) | (vlen == VL_512B));
    rm_sel  = use_emb ? rmode_e'(emb_rm) : rmode_e'(gbl_rm);
  end
endmodule

// File: rtl/f2i_lane_conv.sv
module f2i_lane_conv
  import f2i_pkg::*;
#(
  parameter int unsigned EXP_W = DP_EXP_W,
  parameter int unsigned MAN_W = DP_MAN_W,
  parameter int unsigned INT_W = LANE_W
) (
  input  logic [EXP_W+MAN_W:0] fp_in,
  input  rmode_e               rm,
  output logic [INT_W-1:0]     int_out,
  output logic                 inv_o,
  output logic                 inx_o
);
  localparam int unsigned SIG_W   = MAN_W + 1;
  localparam int unsigned BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned SH_W    = EXP_W + 2;
  localparam int unsigned EDGE_SH = INT_W - 1 - MAN_W;
  localparam int unsigned RS_MAX  = INT_W - 1;
  localparam int unsigned RSH_W   = $clog2(RS_MAX + 1);
  localparam int unsigned LSH_W   = $clog2(EDGE_SH + 1);
  localparam int unsigned EXT_W   = SIG_W + INT_W;

  logic                    sgn;
  logic [EXP_W-1:0]        ex;
  logic [MAN_W-1:0]        man;
  logic [EXP_W-1:0]        ex_eff;
  logic [SIG_W-1:0]        sig;
  logic signed [SH_W-1:0]  sh;
  logic signed [SH_W-1:0]  neg_sh;
  logic [RSH_W-1:0]        rsh;
  logic [LSH_W-1:0]        lsh;
  logic [EXT_W-1:0]        ext;
  logic [SIG_W-1:0]        int_part;
  logic                    rbit;
  logic                    sticky;
  logic                    inc;
  logic [INT_W-1:0]        mag_l;
  logic [INT_W-1:0]        mag;

  // Field split and scale: value = sig * 2^sh
  always_comb begin
    sgn    = fp_in[EXP_W+MAN_W];
    ex     = fp_in[EXP_W+MAN_W-1:MAN_W];
    man    = fp_in[MAN_W-1:0];
    ex_eff = (ex == '0) ? EXP_W'(1) : ex;
    sig    = {(ex != '0), man};
    sh     = $signed({2'b00, ex_eff}) - $signed(SH_W'(BIAS + MAN_W));
    neg_sh = -sh;
  end

  // Right-shift window for fractional values; tiny values clamp to RS_MAX
  always_comb begin
    if (neg_sh > $signed(SH_W'(RS_MAX))) rsh = RSH_W'(RS_MAX);
    else                                 rsh = neg_sh[RSH_W-1:0];
    ext      = {sig, {INT_W{1'b0}}} >> rsh;
    int_part = ext[EXT_W-1:INT_W];
    rbit     = ext[INT_W-1];
    sticky   = |ext[INT_W-2:0];
  end

  // Left-shift path for values that are already integers
  always_comb begin
    lsh   = sh[LSH_W-1:0];
    mag_l = INT_W'(sig) << lsh;
  end

  // Rounding increment by mode
  always_comb begin
    unique case (rm)
      RM_NEAR_EVEN: inc = rbit & (sticky | int_part[0]);
      RM_DOWN:      inc = sgn & (rbit | sticky);
      RM_UP:        inc = ~sgn & (rbit | sticky);
      default:      inc = 1'b0;
    endcase
  end

  // Range resolution and sign application
  always_comb begin
    inv_o   = 1'b0;
    inx_o   = 1'b0;
    mag     = '0;
    int_out = INDEF_Q;
    if (ex == '1) begin
      inv_o = 1'b1;
    end else if ((sh > $signed(SH_W'(EDGE_SH))) ||
                 ((sh == $signed(SH_W'(EDGE_SH))) && !(sgn && (man == '0)))) begin
      inv_o = 1'b1;
    end else begin
      if (sh >= 0) begin
        mag = mag_l;
      end else begin
        mag   = INT_W'(int_part) + INT_W'(inc);
        inx_o = rbit | sticky;
      end
      int_out = sgn ? -mag : mag;
    end
  end
endmodule

// File: rtl/f2i_lane_write.sv
module f2i_lane_write #(
  parameter int unsigned LW = 64
) (
  input  logic          in_len,
  input  logic          wr_en,
  input  logic          zero_mode,
  input  logic [LW-1:0] conv_val,
  input  logic          conv_inv,
  input  logic          conv_inx,
  input  logic [LW-1:0] prior_val,
  output logic [LW-1:0] lane_out,
  output logic          lane_inv,
  output logic          lane_inx
);
  logic live;

  always_comb begin
    live     = in_len & wr_en;
    lane_inv = live & conv_inv;
    lane_inx = live & conv_inx;
    if (!in_len)       lane_out = '0;
    else if (wr_en)    lane_out = conv_val;
    else if (zero_mode) lane_out = '0;
    else               lane_out = prior_val;
  end
endmodule

// File: rtl/vec_f2i_cvt.sv
module vec_f2i_cvt
  import f2i_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES,
  parameter int unsigned LW    = LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES*LW-1:0] src_vec,
  input  logic [1:0]          vlen_sel,
  input  logic [LANES-1:0]    mask_bits,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic [LANES*LW-1:0] prior_dst,
  input  logic                bcast,
  input  logic                src_is_mem,
  input  logic [1:0]          gbl_rm,
  input  logic [1:0]          emb_rm,
  output logic [LANES*LW-1:0] res_vec,
  output logic                flag_invalid,
  output logic                flag_inexact
);
  localparam int unsigned VW  = LANES * LW;
  localparam int unsigned LCW = $clog2(LANES + 1);

  logic [1:0]     rst_sync_q;
  logic           rst_ok_n;
  vlen_e          vlen;
  rmode_e         rm_sel;
  logic [LCW-1:0] lanes_on;
  logic           bc_mode;
  logic [LANES-1:0] lane_in_len;
  logic [LANES-1:0] lane_inv;
  logic [LANES-1:0] lane_inx;
  logic [VW-1:0]  res_d;
  logic           inv_d;
  logic           inx_d;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  // Length decode
  always_comb begin
    vlen    = vlen_e'(vlen_sel);
    bc_mode = src_is_mem & bcast;
    unique case (vlen)
      VL_128:  lanes_on = LCW'(2);
      VL_256:  lanes_on = LCW'(4);
      default: lanes_on = LCW'(LANES);
    endcase
  end

  f2i_rm_pick u_rm_pick (
    .gbl_rm     (gbl_rm),
    .emb_rm     (emb_rm),
    .src_is_mem (src_is_mem),
    .bcast      (bcast),
    .vlen       (vlen),
    .rm_sel     (rm_sel)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LW-1:0] lane_src;
    logic [LW-1:0] conv_val;
    logic          conv_inv;
    logic          conv_inx;
    logic [LW-1:0] lane_out;

    assign lane_in_len[j] = (LCW'(j) < lanes_on);
    assign lane_src = bc_mode ? src_vec[LW-1:0] : src_vec[j*LW +: LW];

    f2i_lane_conv #(
      .EXP_W (DP_EXP_W),
      .MAN_W (DP_MAN_W),
      .INT_W (LW)
    ) u_conv (
      .fp_in   (lane_src),
      .rm      (rm_sel),
      .int_out (conv_val),
      .inv_o   (conv_inv),
      .inx_o   (conv_inx)
    );

    f2i_lane_write #(.LW(LW)) u_wr (
      .in_len    (lane_in_len[j]),
      .wr_en     (!mask_en || mask_bits[j]),
      .zero_mode (zero_mode),
      .conv_val  (conv_val),
      .conv_inv  (conv_inv),
      .conv_inx  (conv_inx),
      .prior_val (prior_dst[j*LW +: LW]),
      .lane_out  (lane_out),
      .lane_inv  (lane_inv[j]),
      .lane_inx  (lane_inx[j])
    );

    assign res_d[j*LW +: LW] = lane_out;
  end

  // Next-state flag collection
  always_comb begin
    inv_d = |lane_inv;
    inx_d = |lane_inx;
  end

  // Output register
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      res_vec      <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      res_vec      <= res_d;
      flag_invalid <= inv_d;
      flag_inexact <= inx_d;
    end
  end

  // R2: upper bits cleared at shortest length
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (vlen_sel == 2'b00) |=> (res_vec[VW-1:2*LW] == '0));

  // R4: merge keeps prior lane 0 when masked off
  p_merge_keep_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mask_en && !zero_mode && !mask_bits[0]) |=> (res_vec[LW-1:0] == $past(prior_dst[LW-1:0])));

  // R4: zeroing clears masked lane 1
  p_zero_lane_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mask_en && zero_mode && !mask_bits[1]) |=> (res_vec[2*LW-1:LW] == '0));

  // R10: no flags when every lane is masked off
  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mask_en && (mask_bits == '0)) |=> (!flag_invalid && !flag_inexact));

  // R5: memory broadcast makes written lanes equal
  p_bcast_same_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (src_is_mem && bcast && !mask_en && (vlen_sel == 2'b01))
      |=> ((res_vec[2*LW-1:LW] == res_vec[LW-1:0]) && (res_vec[4*LW-1:3*LW] == res_vec[LW-1:0])));
endmodule

// File: tb/vec_f2i_cvt_bench.sv
module vec_f2i_cvt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;
  localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [511:0] src_vec;
  logic [1:0]   vlen_sel;
  logic [7:0]   mask_bits;
  logic         mask_en;
  logic         zero_mode;
  logic [511:0] prior_dst;
  logic         bcast;
  logic         src_is_mem;
  logic [1:0]   gbl_rm;
  logic [1:0]   emb_rm;
  logic [511:0] res_vec;
  logic         flag_invalid;
  logic         flag_inexact;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_f2i_cvt u_vec_f2i_cvt (
    .clk(clk), .rst_n(rst_n), .src_vec(src_vec), .vlen_sel(vlen_sel),
    .mask_bits(mask_bits), .mask_en(mask_en), .zero_mode(zero_mode),
    .prior_dst(prior_dst), .bcast(bcast), .src_is_mem(src_is_mem),
    .gbl_rm(gbl_rm), .emb_rm(emb_rm), .res_vec(res_vec),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  // Fixed-point reference for one lane (R7, R8, R9, R11)
  function automatic void ref_lane(input logic [63:0] d, input logic [1:0] rm,
                                   output logic [63:0] q, output logic inv, output logic inx);
    logic s;
    int e;
    int sh;
    logic [52:0] sig;
    logic [255:0] fx;
    logic [127:0] ip;
    logic [127:0] fp;
    logic [129:0] mag;
    logic signed [129:0] v;
    logic up;
    s = d[63];
    e = int'(d[62:52]);
    sig = {(e != 0), d[51:0]};
    inv = 1'b0; inx = 1'b0; q = '0;
    if (e == 2047) begin inv = 1'b1; q = INDEF; return; end
    if (e - 1075 > 12) begin inv = 1'b1; q = INDEF; return; end
    if (e == 0) e = 1;
    sh = e - 1075 + 128;
    if (sh < 0) begin
      ip = '0;
      fp = (sig != 0) ? 128'd1 : 128'd0;
    end else begin
      fx = 256'(sig) << sh;
      ip = fx[255:128];
      fp = fx[127:0];
    end
    case (rm)
      2'b00: up = (fp > {1'b1, 127'b0}) || ((fp == {1'b1, 127'b0}) && ip[0]);
      2'b01: up = s && (fp != 0);
      2'b10: up = !s && (fp != 0);
      default: up = 1'b0;
    endcase
    mag = {2'b00, ip} + 130'(up);
    v = s ? $signed(-mag) : $signed(mag);
    if ((v > $signed(130'h7FFF_FFFF_FFFF_FFFF)) || (v < -$signed(130'h8000_0000_0000_0000))) begin
      inv = 1'b1; q = INDEF; inx = 1'b0;
    end else begin
      q = v[63:0];
      inx = (fp != 0);
    end
  endfunction

  // Whole-vector expectation from the requirements (R1-R6, R10)
  function automatic void ref_vec(output logic [511:0] r, output logic fi, output logic fx);
    int n;
    logic [1:0] rm;
    logic [63:0] q;
    logic li, lx;
    n  = (vlen_sel == 2'b00) ? 2 : (vlen_sel == 2'b01) ? 4 : 8;
    rm = (!src_is_mem && bcast && vlen_sel[1]) ? emb_rm : gbl_rm;
    r = '0; fi = 1'b0; fx = 1'b0;
    for (int j = 0; j < 8; j++) begin
      if (j < n) begin
        if (!mask_en || mask_bits[j]) begin
          ref_lane((src_is_mem && bcast) ? src_vec[63:0] : src_vec[j*64 +: 64], rm, q, li, lx);
          r[j*64 +: 64] = q;
          fi = fi | li;
          fx = fx | lx;
        end else if (!zero_mode) begin
          r[j*64 +: 64] = prior_dst[j*64 +: 64];
        end
      end
    end
  endfunction

  task automatic chk_vec(input string tag, input logic [511:0] act, input logic [511:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s result actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic chk_bit(input string tag, input string what, input logic act, input logic exp_b);
    checks++;
    if (act !== exp_b) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp_b);
    end
  endtask

  // Inputs already driven at a falling edge; result sampled one edge later (R12)
  task automatic run_case(input string tag);
    logic [511:0] er;
    logic ei, ex;
    ref_vec(er, ei, ex);
    @(posedge clk);
    @(negedge clk);
    chk_vec(tag, res_vec, er);
    chk_bit(tag, "invalid", flag_invalid, ei);
    chk_bit(tag, "inexact", flag_inexact, ex);
  endtask

  task automatic set_plain(input logic [1:0] vl, input logic [1:0] rm);
    vlen_sel = vl; mask_en = 1'b0; mask_bits = 8'hFF; zero_mode = 1'b0;
    bcast = 1'b0; src_is_mem = 1'b0; gbl_rm = rm; emb_rm = rm;
    prior_dst = {8{64'h5A5A_0000_1234_5678}};
  endtask

  function automatic logic [63:0] rand_fp();
    logic [63:0] v;
    logic [10:0] ex;
    int k;
    k = int'($urandom % 8);
    v = {$urandom, $urandom};
    case (k)
      0: ;
      1, 2, 3, 4: begin ex = 11'(1023 + ($urandom % 70)); v[62:52] = ex; end
      5: begin ex = 11'(1084 + ($urandom % 4)); v[62:52] = ex; end
      6: begin ex = 11'(1012 + ($urandom % 12)); v[62:52] = ex; end
      default: begin
        case ($urandom % 8)
          0: v = 64'h0000_0000_0000_0000;
          1: v = 64'h8000_0000_0000_0000;
          2: v = 64'h0000_0000_0000_0001;
          3: v = 64'h7FF0_0000_0000_0000;
          4: v = 64'h7FF4_0000_0000_0001;
          5: v = 64'hC3E0_0000_0000_0000;
          6: v = 64'h43E0_0000_0000_0000;
          default: v = 64'hBFE0_0000_0000_0000;
        endcase
      end
    endcase
    return v;
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    set_plain(2'b10, 2'b00);
    src_vec = {8{64'h3FF0_0000_0000_0000}};
    repeat (3) @(negedge clk);
    // R12: outputs held at zero under reset
    chk_vec("R12", res_vec, '0);
    chk_bit("R12", "invalid", flag_invalid, 1'b0);
    chk_bit("R12", "inexact", flag_inexact, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: ties and halves in nearest-even
    set_plain(2'b10, 2'b00);
    src_vec = {64'hBFF8_0000_0000_0000, 64'h3FF8_0000_0000_0000, 64'h3FE0_0000_0000_0000,
               64'hBFE0_0000_0000_0000, 64'hC004_0000_0000_0000, 64'h400C_0000_0000_0000,
               64'h4004_0000_0000_0000, 64'h4000_0000_0000_0000};
    run_case("R7");
    if (res_vec[63:0] !== 64'd2 || res_vec[127:64] !== 64'd2 || res_vec[191:128] !== 64'd4) begin
      fails++;
      $display("FAIL R7 ties actual=%h expected=2,2,4", res_vec[191:0]);
    end
    checks++;
    // R7: each directed mode on the same halves
    for (int m = 1; m < 4; m++) begin
      gbl_rm = 2'(m); emb_rm = 2'(m);
      run_case("R7");
    end

    // R8, R9: range edges and specials
    set_plain(2'b11, 2'b00);
    src_vec = {64'hC3E0_0000_0000_0000, 64'h43E0_0000_0000_0000, 64'h7FF8_0000_0000_0000,
               64'h7FF0_0000_0000_0001, 64'hFFF0_0000_0000_0000, 64'h43DF_FFFF_FFFF_FFFF,
               64'hC3E0_0000_0000_0001, 64'h7FF0_0000_0000_0000};
    run_case("R8");
    src_vec = {8{64'hC3E0_0000_0000_0000}};
    run_case("R9");
    chk_vec("R9", res_vec, {8{INDEF}});
    chk_bit("R9", "invalid", flag_invalid, 1'b0);

    // R11: zeros and subnormals under each mode
    for (int m = 0; m < 4; m++) begin
      set_plain(2'b10, 2'(m));
      src_vec = {64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
                 64'h8000_0000_0000_0001, 64'h000F_FFFF_FFFF_FFFF, 64'h800F_FFFF_FFFF_FFFF,
                 64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000};
      run_case("R11");
    end

    // R6: embedded override only for register form at full width
    set_plain(2'b10, 2'b00);
    emb_rm = 2'b11; bcast = 1'b1;
    src_vec = {8{64'h3FFB_3333_3333_3333}};
    run_case("R6");
    chk_vec("R6", res_vec, {8{64'd1}});
    vlen_sel = 2'b01;
    run_case("R6");
    src_is_mem = 1'b1; vlen_sel = 2'b10;
    run_case("R6");

    // R5: memory broadcast versus register form
    set_plain(2'b10, 2'b10);
    src_vec = {64'h4010_0000_0000_0000, 64'h4008_0000_0000_0000, 64'h4000_0000_0000_0000,
               64'h3FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 64'h4020_0000_0000_0000,
               64'h4018_0000_0000_0000, 64'h4002_0000_0000_0000};
    src_is_mem = 1'b1; bcast = 1'b1;
    run_case("R5");
    chk_vec("R5", res_vec, {8{64'd3}});
    src_is_mem = 1'b0; gbl_rm = 2'b10; emb_rm = 2'b10;
    run_case("R5");

    // R4: merge and zero masking
    set_plain(2'b10, 2'b00);
    src_vec = {8{64'h4059_0000_0000_0000}};
    mask_en = 1'b1; mask_bits = 8'b1010_0110;
    run_case("R4");
    zero_mode = 1'b1;
    run_case("R4");

    // R10: bad lanes masked off or past the length raise nothing
    set_plain(2'b00, 2'b00);
    src_vec = {{6{64'h7FF8_0000_0000_0000}}, 64'h3FF8_0000_0000_0000, 64'h4000_0000_0000_0000};
    mask_en = 1'b1; mask_bits = 8'b1111_1101;
    run_case("R10");
    chk_bit("R10", "invalid", flag_invalid, 1'b0);
    chk_bit("R10", "inexact", flag_inexact, 1'b0);

    // R1, R2: length selects lane count and clears the rest
    for (int v = 0; v < 4; v++) begin
      set_plain(2'(v), 2'b00);
      src_vec = {8{64'hC05E_DD2F_1A9F_BE77}};
      run_case("R1");
    end
    set_plain(2'b01, 2'b00);
    src_vec = {8{64'h7FF0_0000_0000_0000}};
    zero_mode = 1'b0; mask_en = 1'b1; mask_bits = 8'h00;
    run_case("R2");
    chk_vec("R2", {256'b0, res_vec[255:0]} ^ res_vec, '0);

    // R3: constrained random mix
    for (int it = 0; it < 400; it++) begin
      for (int j = 0; j < 8; j++) src_vec[j*64 +: 64] = rand_fp();
      for (int j = 0; j < 16; j++) prior_dst[j*32 +: 32] = $urandom;
      vlen_sel   = 2'($urandom);
      mask_bits  = 8'($urandom);
      mask_en    = 1'($urandom);
      zero_mode  = 1'($urandom);
      bcast      = 1'($urandom);
      src_is_mem = 1'($urandom);
      gbl_rm     = 2'($urandom);
      emb_rm     = 2'($urandom);
      run_case("R3");
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule